// File: doc/BRIEF.md
# Transmit Frame Builder with CRC

This block wraps a payload byte stream into a complete physical-layer transmit frame. A host places the payload length on `frame_len` and pulses `start`. The block then sends, one byte per handshake, four zero preamble bytes, the start-of-frame delimiter 0xA7, a length byte, the payload bytes taken from the upstream port, and finally a 16-bit frame check sequence. The check sequence is computed in hardware while the payload passes through, so the host never supplies it.

Both byte ports use valid/ready handshakes. During the payload phase the upstream port is connected straight through to the downstream port, so the block adds no storage and no latency to payload bytes. A length outside 1..125 is refused with a one-cycle error pulse, and no byte is sent. The end of the frame is marked by a one-cycle `done` pulse.

Top module: `txframe_builder`

## Requirements
- R1: An accepted frame goes out in this order: four bytes of 0x00, then 0xA7, then the length byte, then the payload bytes in arrival order, then two check bytes.
- R2: The length byte equals the requested payload length plus 2, so that it counts the two check bytes.
- R3: The check value is a CRC-16 with polynomial x^16+x^12+x^5+1 and initial value 0. It is computed over the payload bytes only, and each byte is fed least significant bit first. Its low byte goes out before its high byte. For the nine ASCII bytes "123456789" it equals 0x2189.
- R4: A `start` in idle with `frame_len` equal to 0 or greater than 125 raises `start_err` for exactly the cycle after `start`. No byte is sent, and `busy` stays low.
- R5: While `out_ready` is low, the frame stalls at any byte. Header and check bytes keep `out_valid` high and `out_data` unchanged. In the payload phase `pl_ready` follows `out_ready`, so every payload byte is forwarded exactly once.
- R6: `done` is high for exactly one cycle, the cycle after the handshake of the last check byte. In that same cycle `busy` is low.
- R7: A `start` that arrives while a frame is in progress is ignored, and the frame in progress is unchanged.
- R8: After reset, `out_valid`, `pl_ready`, `busy`, `done` and `start_err` are all low.
- R9: `pl_ready` is high only during the payload phase of an accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new frame; sampled in idle |
| frame_len | input | 7 | Payload length in bytes, valid with `start` |
| start_err | output | 1 | One-cycle pulse after a refused request |
| busy | output | 1 | A frame is in progress |
| pl_valid | input | 1 | Upstream payload byte valid |
| pl_data | input | 8 | Upstream payload byte |
| pl_ready | output | 1 | Block takes the payload byte this cycle |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | 8 | Downstream frame byte |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| done | output | 1 | One-cycle pulse after the last check byte |

## Verification
Frames are sent with random lengths and random payloads, while random gaps are put on both the upstream valid and the downstream ready. These runs show whether a stall anywhere in the header, the payload or the check bytes loses, repeats or reorders a byte. Directed frames of length 1 and 125 test the ends of the legal length range. The length values 0, 126 and 127 show that refused requests are kept apart from accepted ones. A frame with the known nine-byte vector pins the CRC bit order and byte order to a fixed value. A second `start` given in the middle of a frame shows that requests during a frame are ignored.

// File: rtl/txfb_pkg.sv
package txfb_pkg;
  localparam logic [7:0] PREAMBLE_BYTE = 8'h00;
  localparam logic [7:0] SFD_BYTE      = 8'hA7;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;  // reflected x^16+x^12+x^5+1

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_LEN, ST_PAY, ST_FCS_LO, ST_FCS_HI
  } txfb_state_e;

  // One payload byte into the running check value, least significant bit first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in, input logic [7:0] din);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REF;
    end
    return c;
  endfunction
endpackage

// File: rtl/txfb_len_check.sv
module txfb_len_check #(
  parameter int MAX_LEN = 125,
  parameter int LEN_W   = 7
) (
  input  logic [LEN_W-1:0] len,
  output logic             len_ok
);
  always_comb len_ok = (len != '0) && (int'(len) <= MAX_LEN);
endmodule

// File: rtl/txfb_crc.sv
module txfb_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import txfb_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (en)    crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/txfb_seq.sv
module txfb_seq #(
  parameter int PRE_LEN = 4,
  parameter int LEN_W   = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  len_ok,
  input  logic [LEN_W-1:0]      frame_len,
  input  logic                  pl_valid,
  input  logic [7:0]            pl_data,
  output logic                  pl_ready,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  input  logic                  out_ready,
  input  logic [15:0]           crc,
  output logic                  crc_clear,
  output logic                  crc_en,
  output logic                  done,
  output logic                  start_err,
  output txfb_pkg::txfb_state_e state
);
  import txfb_pkg::*;

  logic [LEN_W-1:0] cnt, len_q;
  logic             xfer;

  assign xfer      = out_valid && out_ready;
  assign crc_clear = (state == ST_IDLE) && start && len_ok;
  assign crc_en    = (state == ST_PAY) && xfer;

  always_comb begin
    out_valid = 1'b1;
    pl_ready  = 1'b0;
    out_data  = PREAMBLE_BYTE;
    unique case (state)
      ST_IDLE:   out_valid = 1'b0;
      ST_PRE:    out_data  = PREAMBLE_BYTE;
      ST_SFD:    out_data  = SFD_BYTE;
      ST_LEN:    out_data  = 8'(len_q) + 8'd2;
      ST_PAY: begin
        out_valid = pl_valid;
        out_data  = pl_data;
        pl_ready  = out_ready;
      end
      ST_FCS_LO: out_data  = crc[7:0];
      ST_FCS_HI: out_data  = crc[15:8];
      default:   out_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      len_q     <= '0;
      done      <= 1'b0;
      start_err <= 1'b0;
    end else begin
      done      <= 1'b0;
      start_err <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          if (len_ok) begin
            state <= ST_PRE;
            cnt   <= '0;
            len_q <= frame_len;
          end else begin
            start_err <= 1'b1;
          end
        end
        ST_PRE: if (xfer) begin
          cnt <= cnt + 1'b1;
          if (cnt == LEN_W'(PRE_LEN - 1)) state <= ST_SFD;
        end
        ST_SFD: if (xfer) state <= ST_LEN;
        ST_LEN: if (xfer) begin
          state <= ST_PAY;
          cnt   <= '0;
        end
        ST_PAY: if (xfer) begin
          cnt <= cnt + 1'b1;
          if (cnt == len_q - 1'b1) state <= ST_FCS_LO;
        end
        ST_FCS_LO: if (xfer) state <= ST_FCS_HI;
        ST_FCS_HI: if (xfer) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txframe_builder.sv
module txframe_builder #(
  parameter int MAX_LEN = 125,
  parameter int PRE_LEN = 4,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  output logic             start_err,
  output logic             busy,
  input  logic             pl_valid,
  input  logic [7:0]       pl_data,
  output logic             pl_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             done
);
  import txfb_pkg::*;

  logic        len_ok, crc_clear, crc_en;
  logic [15:0] crc;
  txfb_state_e state;

  // Named events for the checker
  logic pay_phase, frame_end;
  assign pay_phase = (state == ST_PAY);
  assign frame_end = (state == ST_FCS_HI) && out_valid && out_ready;
  assign busy      = (state != ST_IDLE);

  txfb_len_check #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .len(frame_len), .len_ok(len_ok)
  );

  txfb_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .en(crc_en),
    .din(pl_data), .crc(crc)
  );

  txfb_seq #(.PRE_LEN(PRE_LEN), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len_ok(len_ok),
    .frame_len(frame_len), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .crc(crc), .crc_clear(crc_clear),
    .crc_en(crc_en), .done(done), .start_err(start_err), .state(state)
  );
endmodule

// File: rtl/txfb_checks.sv
module txfb_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       pl_ready,
  input logic       busy,
  input logic       done,
  input logic       start_err,
  input logic       pay_phase,
  input logic       frame_end
);
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pay_phase) |=> (out_valid && $stable(out_data))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pl_ready && !out_valid)); // R9
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> (!busy && !out_valid)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (done && !busy)); // R6
endmodule

bind txframe_builder txfb_checks u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .pl_ready(pl_ready), .busy(busy), .done(done),
  .start_err(start_err), .pay_phase(pay_phase), .frame_end(frame_end)
);

// File: tb/txframe_builder_bench.sv
`timescale 1ns/1ps
module txframe_builder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] frame_len = '0;
  logic       start_err, busy, pl_ready, out_valid, done;
  logic       pl_valid = 1'b0;
  logic [7:0] pl_data = '0;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] pay [0:127];
  logic [7:0] got [0:255];
  int gcnt;

  always #2.5 clk = ~clk;

  txframe_builder u_txframe_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .start_err(start_err), .busy(busy), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench model of the check value: bit-wise shift with explicit tap flips.
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pay[k][b];
        c = {fb, c[15:1]};
        if (fb) begin c[10] = ~c[10]; c[3] = ~c[3]; end
      end
    return c;
  endfunction

  task automatic run_frame(input int len, input int rdy_pct, input int val_pct,
                           input bit preset, input bit poke, output logic [15:0] fcs);
    int idx = 0, cyc = 0, bad = 0;
    bit seen = 0;
    logic [7:0] exp_b;
    if (!preset) for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    @(negedge clk);
    frame_len = 7'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gcnt = 0;
    while (!seen && cyc < 3000) begin
      out_ready = (($urandom % 100) < rdy_pct);
      if (idx < len) begin
        if (!pl_valid) pl_valid = (($urandom % 100) < val_pct);
        pl_data = pay[idx];
      end else pl_valid = 1'b0;
      if (poke && cyc == 7) begin start = 1'b1; frame_len = 7'd3; end
      else start = 1'b0;
      #1;
      if (out_valid && out_ready && gcnt < 256) begin got[gcnt] = out_data; gcnt++; end
      if (pl_valid && pl_ready) idx++;
      if (done) seen = 1;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; pl_valid = 1'b0; out_ready = 1'b0;
    chk(seen, "R6", "done seen", seen, 1);
    chk(gcnt == len + 8, "R1", "byte count", gcnt, len + 8);
    chk(idx == len, "R5", "payload bytes taken", idx, len);
    fcs = ref_crc(len);
    for (int i = 0; i < gcnt && i < len + 8; i++) begin
      if (i < 4)            exp_b = 8'h00;
      else if (i == 4)      exp_b = 8'hA7;
      else if (i == 5)      exp_b = 8'(len + 2);
      else if (i < len + 6) exp_b = pay[i - 6];
      else if (i == len + 6) exp_b = fcs[7:0];
      else                  exp_b = fcs[15:8];
      if (got[i] !== exp_b) begin
        bad++;
        if (i == 5) chk(0, "R2", "length byte", got[i], exp_b);
        else if (i >= len + 6) chk(0, "R3", "check byte", got[i], exp_b);
        else chk(0, poke ? "R7" : "R1", "frame byte", got[i], exp_b);
      end
    end
    chk(bad == 0, "R1", "frame mismatches", bad, 0);
    #1;
    chk(!done && !busy, "R6", "done one cycle, idle after", {done, busy}, 0);
  endtask

  task automatic bad_start(input int len);
    @(negedge clk);
    frame_len = 7'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(start_err && !out_valid && !busy, "R4", "refused length err pulse", {start_err, out_valid, busy}, 3'b100);
    @(negedge clk);
    #1;
    chk(!start_err && !out_valid && !busy, "R4", "err single cycle, no bytes", {start_err, out_valid, busy}, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] f;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !pl_ready && !busy && !done && !start_err, "R8", "reset outputs",
        {out_valid, pl_ready, busy, done, start_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!pl_ready, "R9", "no payload ready in idle", pl_ready, 0);
    // Known vector
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    run_frame(9, 100, 100, 1'b1, 1'b0, f);
    chk(gcnt == 17 && got[15] == 8'h89 && got[16] == 8'h21, "R3", "known vector fcs",
        {got[16], got[15]}, 16'h2189);
    run_frame(1, 100, 100, 1'b0, 1'b0, f);   // shortest
    run_frame(125, 60, 70, 1'b0, 1'b0, f);   // longest, stalled
    run_frame(20, 50, 50, 1'b0, 1'b1, f);    // R7 start while busy
    bad_start(0);
    bad_start(126);
    bad_start(127);
    for (int n = 0; n < 20; n++)
      run_frame(1 + int'($urandom % 125), 20 + int'($urandom % 81), 20 + int'($urandom % 81), 1'b0, 1'b0, f);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule